// File: doc/BRIEF.md
# Multiplexed GPIO Port

This block is a register-controlled general-purpose I/O port of `NPIN` pins. Software reaches it through a small write/read register bus. Through that bus it sets, for each pin, an output value, a direction, a function select and a resistor enable, and it reads back the sampled pin levels. A pin whose select bit is clear is plain I/O. A pin whose select bit is set belongs to an on-chip serial peripheral, which then supplies both the drive value and the output enable. The register direction bit is disregarded in that case.

The block resolves the pad controls for every pin: drive value, output enable, weak pull enable and pull polarity. It synchronizes incoming pin levels through two flops before they reach software or the peripherals. One pin, chosen by parameter, is shared between the serial clock of unit 1 and the slave-enable input of unit 0, and the clock has priority. While unit 1 claims that pin for its clock, unit 0 is given an idle slave-enable and its effective SPI mode is forced to 3-wire, whatever its configuration.

Top module: `pinmux_port`

## Requirements
- R1: After synchronous reset, output, direction, select and resistor-enable registers are all 0, so every pin is a plain input: pad_oe is 0, pad_pull_en is 0 and every register reads 0.
- R2: For a pin with select 0, pad_out equals its output-register bit and pad_oe equals its direction-register bit (1 = output, 0 = input).
- R3: For a pin with select 1, pad_out and pad_oe come from periph_out and periph_oe, whatever the direction bit holds.
- R4: The pin level reaches periph_in two clock edges after pin_in changes, for either select value. It reads back at address 0 on the third edge when that address is presented.
- R5: Register addresses are 0 input (read-only), 1 output, 2 direction, 3 select and 4 resistor enable. A write takes effect at the clock edge. bus_rdata is registered and shows the addressed value one edge after the address is presented. Addresses 5 to 7 read 0.
- R6: Writes to address 0 and to addresses 5 to 7 change no register and no pad control.
- R7: pad_pull_en is 1 for a pin exactly when its resistor enable is 1 and pad_oe is 0. pad_pull_up carries the output-register bit (1 = pull-up, 0 = pull-down).
- R8: On the shared pin SH_IDX, when u1_clk_req is 1, the peripheral drive comes from periph_out/periph_oe and u0_ste_in is 1 (idle). When u1_clk_req is 0, the peripheral output enable is 0 and u0_ste_in follows the synchronized pin level if that pin's select is 1, and is otherwise 1.
- R9: u0_spi4_eff equals u0_spi4_cfg AND NOT u1_clk_req, so unit 0 is forced to 3-wire mode while unit 1 needs the pin as its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data |
| pin_in | input | NPIN | Sampled pad levels |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad output enable |
| pad_pull_en | output | NPIN | Weak pull enable |
| pad_pull_up | output | NPIN | Pull polarity, 1 = up |
| periph_out | input | NPIN | Peripheral drive values |
| periph_oe | input | NPIN | Peripheral output enables |
| periph_in | output | NPIN | Synchronized pin levels to peripherals |
| u1_clk_req | input | 1 | Unit 1 needs the shared pin as its clock |
| u0_spi4_cfg | input | 1 | Unit 0 configured for 4-wire SPI |
| u0_ste_in | output | 1 | Slave-enable level delivered to unit 0 |
| u0_spi4_eff | output | 1 | Effective 4-wire mode for unit 0 |

## Verification
Pad controls, u0_spi4_eff and u0_ste_in (once the level is synchronized) depend on state and peripheral inputs without a register in between. The bench therefore samples them at the falling edge after the rising edge that commits a write, or at the same falling edge when only peripheral inputs changed. A pin change is first visible on periph_in after two rising edges, and the bench confirms it is still absent after one. Register reads are due one rising edge after the address is driven, so every read presents the address at a falling edge and samples at the next one.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_IN  = 3'd0,
    RA_OUT = 3'd1,
    RA_DIR = 3'd2,
    RA_SEL = 3'd3,
    RA_REN = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic drv;
    logic oe;
    logic pull_en;
    logic pull_up;
  } pad_ctl_t;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end

  assign q = stable_q;
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   in_lvl,
  output logic [NPIN-1:0]   out_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   sel_q,
  output logic [NPIN-1:0]   ren_q,
  output logic [NPIN-1:0]   rdata
);
  logic [NPIN-1:0] rd_mux;

  // register writes; the input address has no storage behind it
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= '0;
      ren_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_OUT:  out_q <= wdata;
        RA_DIR:  dir_q <= wdata;
        RA_SEL:  sel_q <= wdata;
        RA_REN:  ren_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_IN:   rd_mux = in_lvl;
      RA_OUT:  rd_mux = out_q;
      RA_DIR:  rd_mux = dir_q;
      RA_SEL:  rd_mux = sel_q;
      RA_REN:  rd_mux = ren_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
  import pinmux_pkg::*;
(
  input  logic     sel,
  input  logic     dir,
  input  logic     out,
  input  logic     ren,
  input  logic     p_out,
  input  logic     p_oe,
  output pad_ctl_t ctl
);
  logic oe_eff;

  // the owner of the pin provides both value and enable
  assign oe_eff      = sel ? p_oe : dir;
  assign ctl.drv     = sel ? p_out : out;
  assign ctl.oe      = oe_eff;
  assign ctl.pull_en = ren & ~oe_eff;
  assign ctl.pull_up = out;
endmodule

// File: rtl/pinmux_share.sv
module pinmux_share #(
  parameter logic STE_IDLE = 1'b1
) (
  input  logic u1_clk_req,
  input  logic u0_spi4_cfg,
  input  logic sel_sh,
  input  logic lvl_sh,
  input  logic p_out_sh,
  input  logic p_oe_sh,
  output logic arb_out,
  output logic arb_oe,
  output logic ste_lvl,
  output logic spi4_eff
);
  // clock of unit 1 wins; slave-enable of unit 0 is input only
  assign arb_out  = u1_clk_req ? p_out_sh : 1'b0;
  assign arb_oe   = u1_clk_req ? p_oe_sh  : 1'b0;
  assign ste_lvl  = (u1_clk_req || !sel_sh) ? STE_IDLE : lvl_sh;
  assign spi4_eff = u0_spi4_cfg & ~u1_clk_req;
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int   NPIN     = 8,
  parameter int   SH_IDX   = 3,
  parameter logic STE_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pull_en,
  output logic [NPIN-1:0]   pad_pull_up,
  input  logic [NPIN-1:0]   periph_out,
  input  logic [NPIN-1:0]   periph_oe,
  output logic [NPIN-1:0]   periph_in,
  input  logic              u1_clk_req,
  input  logic              u0_spi4_cfg,
  output logic              u0_ste_in,
  output logic              u0_spi4_eff
);
  logic [NPIN-1:0] out_q, dir_q, sel_q, ren_q;
  logic [NPIN-1:0] lvl;
  logic            arb_out, arb_oe;

  pinmux_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  pinmux_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .in_lvl(lvl), .out_q(out_q), .dir_q(dir_q), .sel_q(sel_q), .ren_q(ren_q),
    .rdata(bus_rdata)
  );

  pinmux_share #(.STE_IDLE(STE_IDLE)) u_share (
    .u1_clk_req(u1_clk_req), .u0_spi4_cfg(u0_spi4_cfg),
    .sel_sh(sel_q[SH_IDX]), .lvl_sh(lvl[SH_IDX]),
    .p_out_sh(periph_out[SH_IDX]), .p_oe_sh(periph_oe[SH_IDX]),
    .arb_out(arb_out), .arb_oe(arb_oe),
    .ste_lvl(u0_ste_in), .spi4_eff(u0_spi4_eff)
  );

  assign periph_in = lvl;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic     p_out_i, p_oe_i;
    pad_ctl_t ctl_i;

    if (i == SH_IDX) begin : g_shared
      assign p_out_i = arb_out;
      assign p_oe_i  = arb_oe;
    end else begin : g_plain
      assign p_out_i = periph_out[i];
      assign p_oe_i  = periph_oe[i];
    end

    pinmux_pin u_pin (
      .sel(sel_q[i]), .dir(dir_q[i]), .out(out_q[i]), .ren(ren_q[i]),
      .p_out(p_out_i), .p_oe(p_oe_i), .ctl(ctl_i)
    );

    assign pad_out[i]     = ctl_i.drv;
    assign pad_oe[i]      = ctl_i.oe;
    assign pad_pull_en[i] = ctl_i.pull_en;
    assign pad_pull_up[i] = ctl_i.pull_up;
  end
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
  import pinmux_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int SH_IDX = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_pull_en,
  input logic [NPIN-1:0]   periph_out,
  input logic [NPIN-1:0]   periph_oe,
  input logic [NPIN-1:0]   periph_in,
  input logic              u1_clk_req,
  input logic              u0_ste_in,
  input logic              u0_spi4_eff,
  input logic [NPIN-1:0]   out_q,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   sel_q
);
  logic [1:0] warm_q;

  always_ff @(posedge clk) begin
    if (rst)                warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sel_q == '0 && dir_q == '0 && pad_oe == '0));

  p_write_out_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_OUT) |=> out_q == $past(bus_wdata));

  p_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> periph_in == $past(pin_in, 2));

  p_pull_r7: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);

  p_ste_idle_r8: assert property (@(posedge clk) disable iff (rst)
    u1_clk_req |-> u0_ste_in);

  p_spi3_r9: assert property (@(posedge clk) disable iff (rst)
    u1_clk_req |-> !u0_spi4_eff);

  for (genvar i = 0; i < NPIN; i++) begin : g_own
    p_gpio_r2: assert property (@(posedge clk) disable iff (rst)
      !sel_q[i] |-> (pad_out[i] == out_q[i] && pad_oe[i] == dir_q[i]));
    if (i != SH_IDX) begin : g_np
      p_periph_r3: assert property (@(posedge clk) disable iff (rst)
        sel_q[i] |-> (pad_out[i] == periph_out[i] && pad_oe[i] == periph_oe[i]));
    end
  end
endmodule

bind pinmux_port pinmux_port_chk #(.NPIN(NPIN), .SH_IDX(SH_IDX)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pull_en(pad_pull_en), .periph_out(periph_out), .periph_oe(periph_oe),
  .periph_in(periph_in), .u1_clk_req(u1_clk_req), .u0_ste_in(u0_ste_in),
  .u0_spi4_eff(u0_spi4_eff), .out_q(out_q), .dir_q(dir_q), .sel_q(sel_q)
);

// File: tb/pinmux_port_bench.sv
module pinmux_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
  logic [7:0] periph_out = 8'h00;
  logic [7:0] periph_oe = 8'h00;
  logic [7:0] periph_in;
  logic       u1_clk_req = 1'b0;
  logic       u0_spi4_cfg = 1'b0;
  logic       u0_ste_in, u0_spi4_eff;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pinmux_port u_pinmux_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in), .u1_clk_req(u1_clk_req), .u0_spi4_cfg(u0_spi4_cfg),
    .u0_ste_in(u0_ste_in), .u0_spi4_eff(u0_spi4_eff)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pull_en", pad_pull_en, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 8'h00);
    end
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h0F); wr(3'd4, 8'hC3);
    rd(3'd1, v); chk("R5 out", v, 8'hA5);
    rd(3'd2, v); chk("R5 dir", v, 8'h3C);
    rd(3'd3, v); chk("R5 sel", v, 8'h0F);
    rd(3'd4, v); chk("R5 ren", v, 8'hC3);
    rd(3'd5, v); chk("R5 unused", v, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] v, oe0, o0;
    oe0 = pad_oe; o0 = pad_out;
    wr(3'd0, 8'hFF); wr(3'd6, 8'h5A); wr(3'd7, 8'hFF);
    rd(3'd1, v); chk("R6 out kept", v, 8'hA5);
    rd(3'd2, v); chk("R6 dir kept", v, 8'h3C);
    rd(3'd3, v); chk("R6 sel kept", v, 8'h00);
    rd(3'd4, v); chk("R6 ren kept", v, 8'h00);
    chk("R6 pad_oe", pad_oe, oe0);
    chk("R6 pad_out", pad_out, o0);
  endtask

  task automatic t_owner;
    u1_clk_req = 1'b1;
    periph_out = 8'hC3; periph_oe = 8'h96;
    wr(3'd1, 8'h5A);
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        wr(3'd3, s ? 8'hFF : 8'h00);
        wr(3'd2, d ? 8'hFF : 8'h00);
        @(negedge clk);
        if (s == 0) begin
          chk("R2 pad_out", pad_out, 8'h5A);
          chk("R2 pad_oe", pad_oe, d ? 8'hFF : 8'h00);
        end else begin
          chk("R3 pad_out", pad_out, 8'hC3);
          chk("R3 pad_oe", pad_oe, 8'h96);
        end
      end
    end
    periph_oe = 8'h69;
    @(negedge clk);
    chk("R3 oe follows periph", pad_oe, 8'h69);
    wr(3'd3, 8'h00); wr(3'd2, 8'h00);
    u1_clk_req = 1'b0;
  endtask

  task automatic t_input;
    logic [7:0] v;
    logic [7:0] pat [2] = '{8'hA5, 8'h5A};
    for (int s = 0; s < 2; s++) begin
      wr(3'd3, s ? 8'hFF : 8'h00);
      for (int k = 0; k < 2; k++) begin
        logic [7:0] prev;
        prev = periph_in;
        @(negedge clk);
        pin_in = pat[k];
        @(negedge clk);
        chk("R4 not yet", periph_in, prev);
        @(negedge clk);
        chk("R4 periph_in", periph_in, pat[k]);
        rd(3'd0, v);
        chk("R4 read", v, pat[k]);
      end
    end
    wr(3'd3, 8'h00);
  endtask

  task automatic t_pull;
    wr(3'd1, 8'h33); wr(3'd2, 8'h0F); wr(3'd4, 8'hFF);
    @(negedge clk);
    chk("R7 pull_en", pad_pull_en, 8'hF0);
    chk("R7 pull_up", pad_pull_up, 8'h33);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_shared;
    wr(3'd3, 8'h08);
    periph_out = 8'h08; periph_oe = 8'h08;
    u0_spi4_cfg = 1'b1; u1_clk_req = 1'b0;
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 4-wire kept", {7'd0, u0_spi4_eff}, 8'h01);
    chk("R8 ste follows pin", {7'd0, u0_ste_in}, 8'h00);
    chk("R8 oe blocked", {7'd0, pad_oe[3]}, 8'h00);
    u1_clk_req = 1'b1;
    @(negedge clk);
    chk("R9 forced 3-wire", {7'd0, u0_spi4_eff}, 8'h00);
    chk("R8 ste idle", {7'd0, u0_ste_in}, 8'h01);
    chk("R8 clock drives", {7'd0, pad_oe[3]}, 8'h01);
    u0_spi4_cfg = 1'b0; u1_clk_req = 1'b0;
    @(negedge clk);
    chk("R9 cfg off", {7'd0, u0_spi4_eff}, 8'h00);
    wr(3'd3, 8'h00);
    @(negedge clk);
    chk("R8 ste idle gpio", {7'd0, u0_ste_in}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_ignored();
    t_owner();
    t_input();
    t_pull();
    t_shared();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule